// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a memory-mapped watchdog for a system chip. Software loads a cycle count into the timer register and then picks an expiry action in the control register. While an action is selected, a down-counter loses one per clock. If software does not reload the timer before the count reaches zero, the block raises one of three outputs: a level interrupt, a level non-maskable interrupt, or a one-cycle request to the chip reset controller.

A timer write takes effect only after a fixed settling delay. During that delay the old count keeps running. This lets software load the timer first and arm the action a short time later. A flag that only a power-on reset clears records that the last chip reset came from the watchdog. Software reads this flag after boot and clears it by writing a one to it.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0x00000000 (when power-on reset was also applied), the timer register reads 0xFFFFFFFF, and irq_o, nmi_o and chip_rst_req_o are low.
- R2: Offset 0x0 is the control register: bits [1:0] hold the action code (0 off, 1 interrupt, 2 non-maskable interrupt, 3 chip reset), bit 31 holds the watchdog-reset flag, and the other bits read 0. Offset 0x4 is the timer register, and a read returns the live count. Reads are combinational from req_addr.
- R3: A timer write sampled at clock edge E loads the counter at edge E+4 (SETTLE=4). Until then the old count keeps its behaviour. A second write inside that window replaces the pending value and restarts the 4-cycle delay.
- R4: While the action code is non-zero, the count falls by exactly one per clock. With action 0 it does not change.
- R5: With action 1, irq_o goes high on the edge after the count is seen at zero. It stays high until a reload takes effect or action 0 is in force.
- R6: With action 2, nmi_o behaves as irq_o does in R5.
- R7: With action 3, chip_rst_req_o is high for exactly one cycle on the edge after the count is seen at zero.
- R8: Each load fires at most once. After firing, the count holds at zero and no second event occurs until the next reload. At most one of the three outputs is high at any time.
- R9: The flag in bit 31 is set the cycle after chip_rst_req_o. It is kept through rst_n and cleared only by por_n or by a control write with bit 31 = 1. When a set and a clear fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Active-low reset for everything except the watchdog-reset flag |
| por_n | input | 1 | Active-low power-on reset; also clears the watchdog-reset flag |
| req_valid | input | 1 | Bus access strobe |
| req_write | input | 1 | 1 = write access |
| req_addr | input | 3 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for req_addr |
| irq_o | output | 1 | Level interrupt on expiry (action 1) |
| nmi_o | output | 1 | Level non-maskable interrupt on expiry (action 2) |
| chip_rst_req_o | output | 1 | One-cycle chip reset request on expiry (action 3) |

## Verification
Two events can land on one edge: the flag being set by a reset request, and software clearing that flag. The bench arms action 3 with a count of 2. It times a control write of 0x80000003 so that the write is sampled on the same edge where the request pulse sets the flag. The read-back must still show bit 31 = 1, and a later clear-only write must take it to 0.

The bench also checks that a reload written while the count runs leaves the old count decrementing for the full settling window. Where a second write lands inside that window, the first pending value must never appear in the count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    ACT_OFF     = 2'd0,
    ACT_INT     = 2'd1,
    ACT_NMI     = 2'd2,
    ACT_CHIPRST = 2'd3
  } wd_act_e;

  localparam int OFFS_W      = 3;
  localparam logic [OFFS_W-1:0] CTRL_OFS  = 3'h0;
  localparam logic [OFFS_W-1:0] TIMER_OFS = 3'h4;

  // Layout of the control word as software sees it.
  function automatic logic [31:0] f_ctrl_word(input logic cause, input wd_act_e act);
    logic [31:0] w;
    w        = '0;
    w[31]    = cause;
    w[1:0]   = act;
    return w;
  endfunction

  function automatic logic f_armed(input wd_act_e act);
    return act != ACT_OFF;
  endfunction

  function automatic logic f_at_zero(input logic [31:0] c);
    return c == '0;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    por_n,
  input  logic    wr_ctrl,
  input  logic [1:0] wr_act,
  input  logic    wr_clr_cause,
  input  logic    set_cause,
  output wd_act_e action_q,
  output logic    cause_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) action_q <= ACT_OFF;
    else if (wr_ctrl) action_q <= wd_act_e'(wr_act);
  end

  // Power-on domain only: survives the chip reset this block requests.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause_q <= 1'b0;
    else if (set_cause) cause_q <= 1'b1;
    else if (wr_ctrl && wr_clr_cause) cause_q <= 1'b0;
  end

endmodule

// File: rtl/wdog_settle.sv
module wdog_settle #(
  parameter int DW     = 32,
  parameter int SETTLE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          load_o,
  output logic [DW-1:0] load_val_o
);

  localparam int LW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [LW-1:0] LEFT_INIT = LW'(SETTLE - 1);

  logic          pend_q;
  logic [LW-1:0] left_q;

  assign load_o = pend_q && (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      left_q     <= '0;
      load_val_o <= '0;
    end else if (wr) begin
      pend_q     <= 1'b1;
      left_q     <= LEFT_INIT;
      load_val_o <= wdata;
    end else if (load_o) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wd_act_e       action,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] count_q,
  output logic          expire_evt,
  output logic          irq_q,
  output logic          nmi_q,
  output logic          rst_req_q
);

  logic armed;
  logic fired_q;
  logic at_zero;

  assign armed      = f_armed(action);
  assign at_zero    = (count_q == '0);
  assign expire_evt = armed && at_zero && !fired_q && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '1;
      fired_q <= 1'b0;
    end else begin
      if (load) begin
        count_q <= load_val;
        fired_q <= 1'b0;
      end else begin
        if (armed && !at_zero) count_q <= count_q - 1'b1;
        if (expire_evt) fired_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= 1'b0;
      nmi_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      irq_q     <= (irq_q && armed && !load) || (expire_evt && action == ACT_INT);
      nmi_q     <= (nmi_q && armed && !load) || (expire_evt && action == ACT_NMI);
      rst_req_q <= expire_evt && action == ACT_CHIPRST;
    end
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DW     = 32,
  parameter int SETTLE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [OFFS_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic [DW-1:0]     rsp_rdata,
  output logic              irq_o,
  output logic              nmi_o,
  output logic              chip_rst_req_o
);

  logic          wr_ctrl, wr_timer;
  wd_act_e       action_q;
  logic          cause_q;
  logic          armed;
  logic          load_apply;
  logic [DW-1:0] load_val;
  logic [DW-1:0] count_q;
  logic          expire_evt;

  assign wr_ctrl  = req_valid && req_write && (req_addr == CTRL_OFS);
  assign wr_timer = req_valid && req_write && (req_addr == TIMER_OFS);
  assign armed    = f_armed(action_q);

  wdog_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_n       (por_n),
    .wr_ctrl     (wr_ctrl),
    .wr_act      (req_wdata[1:0]),
    .wr_clr_cause(req_wdata[DW-1]),
    .set_cause   (chip_rst_req_o),
    .action_q    (action_q),
    .cause_q     (cause_q)
  );

  wdog_settle #(.DW(DW), .SETTLE(SETTLE)) u_settle (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr_timer),
    .wdata     (req_wdata),
    .load_o    (load_apply),
    .load_val_o(load_val)
  );

  wdog_core #(.DW(DW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .action    (action_q),
    .load      (load_apply),
    .load_val  (load_val),
    .count_q   (count_q),
    .expire_evt(expire_evt),
    .irq_q     (irq_o),
    .nmi_q     (nmi_o),
    .rst_req_q (chip_rst_req_o)
  );

  always_comb begin
    unique case (req_addr)
      CTRL_OFS:  rsp_rdata = DW'(f_ctrl_word(cause_q, action_q));
      TIMER_OFS: rsp_rdata = count_q;
      default:   rsp_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          por_n,
  input logic          armed,
  input logic          load,
  input logic [DW-1:0] cnt,
  input logic          irq,
  input logic          nmi,
  input logic          rst_req,
  input logic          cause
);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !load) |=> $stable(cnt));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_one_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq, nmi, rst_req}));

  assert_irq_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cnt) == '0);

  assert_nmi_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> $past(cnt) == '0);

  assert_cause_set_R9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rst_req |=> cause);

endmodule

bind wdog_timer wdog_checker #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .por_n  (por_n),
  .armed  (armed),
  .load   (load_apply),
  .cnt    (count_q),
  .irq    (irq_o),
  .nmi    (nmi_o),
  .rst_req(chip_rst_req_o),
  .cause  (cause_q)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;

  localparam int SETTLE = 4;
  localparam logic [2:0] A_CTRL = 3'h0;
  localparam logic [2:0] A_TMR  = 3'h4;
  localparam int NV = 5;
  localparam logic [1:0]  V_ACT [NV] = '{2'd1, 2'd2, 2'd3, 2'd1, 2'd0};
  localparam logic [31:0] V_LOAD[NV] = '{32'd5, 32'd3, 32'd7, 32'd1, 32'd4};
  localparam logic [2:0]  V_EXP [NV] = '{3'b001, 3'b010, 3'b100, 3'b001, 3'b000};

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic irq_o, nmi_o, chip_rst_req_o;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .irq_o(irq_o), .nmi_o(nmi_o), .chip_rst_req_o(chip_rst_req_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    req_addr = a; #1; d = rsp_rdata;
  endtask

  function automatic logic [31:0] outs();
    return {29'd0, chip_rst_req_o, nmi_o, irq_o};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, a, b;
    repeat (3) @(posedge clk); #1;
    por_n = 1'b1; rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, d); chk("R1 ctrl after reset", d, 32'h0);
    rd(A_TMR, d);  chk("R1 timer after reset", d, 32'hFFFF_FFFF);
    chk("R1 outputs after reset", outs(), 32'h0);
    idle(3);
    rd(A_TMR, d);  chk("R4 timer frozen while off", d, 32'hFFFF_FFFF);

    // Table of action/load/expected-output vectors
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = V_LOAD[i];
      wr(A_CTRL, 32'h0);
      wr(A_TMR, v);
      idle(SETTLE);
      rd(A_TMR, d); chk("R3 loaded after settle", d, v);
      wr(A_CTRL, {30'd0, V_ACT[i]});
      rd(A_CTRL, d); chk("R2 action readback", d, {30'd0, V_ACT[i]});
      idle(int'(v));
      rd(A_TMR, d); chk("R4 count at expiry", d, (V_ACT[i] == 2'd0) ? v : 32'h0);
      chk("R8 outputs before fire", outs(), 32'h0);
      idle(1);
      chk("R5 R6 R7 expiry output", outs(), {29'd0, V_EXP[i]});
      idle(1);
      chk("R7 R5 R6 output one cycle later", outs(),
          (V_ACT[i] == 2'd3) ? 32'h0 : {29'd0, V_EXP[i]});
      rd(A_CTRL, d);
      chk("R9 flag after request", {31'd0, d[31]}, {31'd0, V_ACT[i] == 2'd3});
      idle(3);
      rd(A_TMR, d); chk("R8 count held after fire", d, (V_ACT[i] == 2'd0) ? v : 32'h0);
      chk("R8 no refire", outs(), (V_ACT[i] == 2'd3) ? 32'h0 : {29'd0, V_EXP[i]});
      wr(A_CTRL, 32'h8000_0000);
      idle(1);
      chk("R5 R6 outputs clear on action 0", outs(), 32'h0);
      rd(A_CTRL, d); chk("R9 flag cleared by write", d, 32'h0);
    end

    // R5 reload clears interrupt at apply edge
    wr(A_TMR, 32'd3); idle(SETTLE);
    wr(A_CTRL, 32'd1); idle(4);
    chk("R5 irq raised", {31'd0, irq_o}, 32'd1);
    wr(A_TMR, 32'd10); idle(SETTLE - 1);
    chk("R5 irq held during settle", {31'd0, irq_o}, 32'd1);
    idle(1);
    chk("R5 irq cleared by reload", {31'd0, irq_o}, 32'd0);
    rd(A_TMR, d); chk("R3 reload value", d, 32'd10);
    idle(1);
    rd(A_TMR, d); chk("R4 step after reload", d, 32'd9);

    // R3 old count runs during window, second write replaces first
    wr(A_TMR, 32'd200);
    idle(1); rd(A_TMR, a);
    idle(1); rd(A_TMR, b);
    chk("R3 R4 old count keeps running", b, a - 32'd1);
    wr(A_TMR, 32'd300);
    idle(SETTLE - 1);
    rd(A_TMR, d); chk("R3 pending value replaced", d, b - 32'd4);
    idle(1);
    rd(A_TMR, d); chk("R3 replacing value applied", d, 32'd300);
    wr(A_CTRL, 32'h0);

    // R9 set and clear on the same edge: set wins
    wr(A_TMR, 32'd2); idle(SETTLE);
    wr(A_CTRL, 32'd3); idle(3);
    chk("R7 request high", {31'd0, chip_rst_req_o}, 32'd1);
    wr(A_CTRL, 32'h8000_0003);
    rd(A_CTRL, d); chk("R9 set wins over clear", d, 32'h8000_0003);

    // R9 flag survives rst_n, cleared by por_n
    rst_n = 1'b0; #2; rst_n = 1'b1; idle(1);
    rd(A_CTRL, d); chk("R9 flag kept through rst_n", d, 32'h8000_0000);
    rd(A_TMR, d);  chk("R1 timer after rst_n", d, 32'hFFFF_FFFF);
    por_n = 1'b0; rst_n = 1'b0; #2; por_n = 1'b1; rst_n = 1'b1; idle(1);
    rd(A_CTRL, d); chk("R9 flag cleared by por_n", d, 32'h0);
    rd(3'h2, d);   chk("R2 unused offset reads 0", d, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule